// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block produces the feedback-divider timing for a fractional-N phase-locked loop. A clock-enable pulse from the RF side marks each cycle of the oscillator output. A dual-modulus prescaler model, selectable between 4/5 and 8/9, is steered by a pulse-swallow counter pair. Together they count one division of N such cycles and then emit a one-cycle pulse toward the phase detector.

A first-order sigma-delta accumulator with a programmable modulus chooses the N of each division. N is either the integer setting or the integer setting plus one, so that over many divisions the mean ratio is INT + FRAC/MOD. New integer, fraction, modulus and prescaler settings are taken only at the end of a division. A separate small counter divides a reference clock-enable stream by a 4-bit value before it reaches the phase detector.

Top module: `fnd_fb_divider`

## Requirements
- R1: While rst_ni is low, fb_pulse_o, pre_pulse_o, ref_pulse_o and int_clamp_o are 0, and n_cur_o is 16, whatever the tick inputs do.
- R2: With frac_i = 0, every division spans exactly int_i cycles of rf_tick_i, for either prescaler setting.
- R3: Prescaler size is P = 4 when psc_sel_i = 0 and P = 8 when psc_sel_i = 1. For a division of N, with B = floor(N/P) and A = N mod P, the prescaler output (pre_pulse_o) comes after P+1 ticks for each of the first A prescaler cycles and after P ticks for each of the remaining B-A cycles.
- R4: The accumulator is 0 after reset. At each load it adds the fraction. When the sum reaches MOD, MOD is subtracted and that division is INT+1; otherwise the division is INT.
- R5: Over any MOD consecutive divisions after reset, the total number of ticks is MOD*INT + FRAC, for a modulus that need not be a power of two.
- R6: A frac_i at or above the effective modulus acts as modulus-1. A mod_i of 0 acts as 1.
- R7: An int_i below P*P is replaced by P*P (64 or 16) before the carry is added, and int_clamp_o is 1 for that division. Otherwise int_clamp_o is 0.
- R8: Settings are sampled on the clock edge that completes a division, and on the first edge after reset. n_cur_o shows the N of the division in progress and changes only on those edges.
- R9: Only cycles with rf_tick_i high advance the count. fb_pulse_o is high for one cycle, in the cycle after the tick that completes the division. A tick in the first cycle after reset is not counted.
- R10: ref_pulse_o is high for one cycle after every R-th ref_tick_i, where R = ref_div_i, and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_tick_i | input | 1 | One RF output cycle |
| ref_tick_i | input | 1 | One reference cycle |
| int_i | input | INT_W | Integer part of the ratio |
| frac_i | input | FRAC_W | Fraction numerator |
| mod_i | input | FRAC_W | Fraction modulus |
| psc_sel_i | input | 1 | Prescaler select: 0 = 4/5, 1 = 8/9 |
| ref_div_i | input | REF_W | Reference divide value |
| fb_pulse_o | output | 1 | Pulse per completed division |
| pre_pulse_o | output | 1 | Pulse per prescaler output cycle |
| ref_pulse_o | output | 1 | Divided reference pulse |
| n_cur_o | output | INT_W+1 | N of the division in progress |
| int_clamp_o | output | 1 | Integer setting below the legal minimum |

## Verification
Plain integer settings on both prescalers show that the swallow counters build N exactly. The prescaler pulse spacing then shows the split into P+1 and P cycles. A short fraction of 1/3 pins the exact carry positions. Modulus 7 and modulus 13 runs, summed over one full modulus, show that the mean ratio holds for a modulus that is not a power of two. Oversized fractions, a zero modulus and integer values just below and at the floor separate the clamping rules from the carry path. A setting changed in mid-division, and a tick stream with gaps, show that the division boundary and the tick enable are the only things that move the count.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  typedef enum logic {PSC_4_5 = 1'b0, PSC_8_9 = 1'b1} psc_e;

  // smallest legal integer divide: P*P
  function automatic logic [6:0] n_floor(input logic hi);
    return hi ? 7'd64 : 7'd16;
  endfunction
endpackage

// File: rtl/fnd_sdm.sv
module fnd_sdm import fnd_pkg::*; #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 12,
  localparam int unsigned N_W   = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] mod_i,
  input  logic              p8_i,
  output logic [N_W-1:0]    n_o,
  output logic              clamp_o,
  output logic [FRAC_W-1:0] acc_o,
  output logic [FRAC_W-1:0] mod_o
);
  logic [FRAC_W-1:0] mod_eff, frac_eff, acc_q, mod_q, acc_base, acc_nxt;
  logic [FRAC_W:0]   sum;
  logic              carry;
  logic [N_W-1:0]    n_min, int_ext, int_eff;

  always_comb begin
    mod_eff  = (mod_i == '0) ? FRAC_W'(1) : mod_i;
    frac_eff = (frac_i >= mod_eff) ? mod_eff - FRAC_W'(1) : frac_i;
    // a modulus shrunk below the held residue restarts the residue
    acc_base = (acc_q >= mod_eff) ? '0 : acc_q;
    sum      = {1'b0, acc_base} + {1'b0, frac_eff};
    carry    = sum >= {1'b0, mod_eff};
    acc_nxt  = carry ? FRAC_W'(sum - {1'b0, mod_eff}) : sum[FRAC_W-1:0];
    n_min    = N_W'(n_floor(p8_i));
    int_ext  = {1'b0, int_i};
    clamp_o  = int_ext < n_min;
    int_eff  = clamp_o ? n_min : int_ext;
    n_o      = int_eff + N_W'(carry);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mod_q <= FRAC_W'(1);
    end else if (load_i) begin
      acc_q <= acc_nxt;
      mod_q <= mod_eff;
    end
  end

  assign acc_o = acc_q;
  assign mod_o = mod_q;
endmodule

// File: rtl/fnd_pswallow.sv
module fnd_pswallow #(
  parameter int unsigned N_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           load_i,
  input  logic [N_W-1:0] n_i,
  input  logic           p8_i,
  output logic           pre_o,
  output logic           done_o,
  output logic           p8_o
);
  localparam int unsigned PC_W = 4;

  logic            p8_q;
  logic [N_W-1:0]  b_q, m_cnt_q, b_nxt;
  logic [2:0]      a_q, a_nxt;
  logic [PC_W-1:0] pre_cnt_q, p_mod;
  logic            pre_last, m_last;

  always_comb begin
    b_nxt    = p8_i ? (n_i >> 3) : (n_i >> 2);
    a_nxt    = p8_i ? n_i[2:0] : {1'b0, n_i[1:0]};
    // swallow phase: P+1 while fewer than A prescaler cycles are done
    p_mod    = (p8_q ? PC_W'(8) : PC_W'(4)) +
               ((m_cnt_q < N_W'(a_q)) ? PC_W'(1) : PC_W'(0));
    pre_last = pre_cnt_q == p_mod - PC_W'(1);
    m_last   = m_cnt_q == b_q - N_W'(1);
    pre_o    = tick_i & pre_last;
    done_o   = pre_o & m_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p8_q      <= 1'b0;
      b_q       <= N_W'(4);
      a_q       <= '0;
      pre_cnt_q <= '0;
      m_cnt_q   <= '0;
    end else if (load_i) begin
      p8_q      <= p8_i;
      b_q       <= b_nxt;
      a_q       <= a_nxt;
      pre_cnt_q <= '0;
      m_cnt_q   <= '0;
    end else if (tick_i) begin
      if (pre_last) begin
        pre_cnt_q <= '0;
        m_cnt_q   <= m_last ? '0 : m_cnt_q + N_W'(1);
      end else begin
        pre_cnt_q <= pre_cnt_q + PC_W'(1);
      end
    end
  end

  assign p8_o = p8_q;
endmodule

// File: rtl/fnd_ref_div.sv
module fnd_ref_div #(
  parameter int unsigned REF_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REF_W-1:0] div_i,
  output logic             pulse_o
);
  logic [REF_W-1:0] cnt_q, r_eff;
  logic             last;

  always_comb begin
    r_eff   = (div_i == '0) ? REF_W'(1) : div_i;
    last    = cnt_q >= r_eff - REF_W'(1);
    pulse_o = tick_i & last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + REF_W'(1);
  end
endmodule

// File: rtl/fnd_fb_divider.sv
module fnd_fb_divider import fnd_pkg::*; #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned REF_W  = 4,
  localparam int unsigned N_W   = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rf_tick_i,
  input  logic              ref_tick_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] mod_i,
  input  logic              psc_sel_i,
  input  logic [REF_W-1:0]  ref_div_i,
  output logic              fb_pulse_o,
  output logic              pre_pulse_o,
  output logic              ref_pulse_o,
  output logic [N_W-1:0]    n_cur_o,
  output logic              int_clamp_o
);
  logic              start_q, load, done, pre, ref_pulse, clamp, p8_sel, p8_act;
  logic [N_W-1:0]    n_nxt;
  logic [FRAC_W-1:0] acc_cur, mod_cur;

  assign p8_sel = psc_e'(psc_sel_i) == PSC_8_9;
  assign load   = start_q | done;

  fnd_sdm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sdm (
    .clk_i, .rst_ni, .load_i(load), .int_i, .frac_i, .mod_i, .p8_i(p8_sel),
    .n_o(n_nxt), .clamp_o(clamp), .acc_o(acc_cur), .mod_o(mod_cur)
  );

  fnd_pswallow #(.N_W(N_W)) u_pswallow (
    .clk_i, .rst_ni, .tick_i(rf_tick_i), .load_i(load), .n_i(n_nxt), .p8_i(p8_sel),
    .pre_o(pre), .done_o(done), .p8_o(p8_act)
  );

  fnd_ref_div #(.REF_W(REF_W)) u_ref_div (
    .clk_i, .rst_ni, .tick_i(ref_tick_i), .div_i(ref_div_i), .pulse_o(ref_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q     <= 1'b1;
      fb_pulse_o  <= 1'b0;
      pre_pulse_o <= 1'b0;
      ref_pulse_o <= 1'b0;
      n_cur_o     <= N_W'(16);
      int_clamp_o <= 1'b0;
    end else begin
      start_q     <= 1'b0;
      fb_pulse_o  <= done;
      pre_pulse_o <= pre;
      ref_pulse_o <= ref_pulse;
      if (load) begin
        n_cur_o     <= n_nxt;
        int_clamp_o <= clamp;
      end
    end
  end
endmodule

// File: rtl/fnd_fb_divider_chk.sv
module fnd_fb_divider_chk #(
  parameter int unsigned N_W    = 13,
  parameter int unsigned FRAC_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rf_tick_i,
  input logic              ref_tick_i,
  input logic              fb_pulse_o,
  input logic              pre_pulse_o,
  input logic              ref_pulse_o,
  input logic [N_W-1:0]    n_cur_o,
  input logic              int_clamp_o,
  input logic              start_q,
  input logic              p8_q,
  input logic [FRAC_W-1:0] acc_q,
  input logic [FRAC_W-1:0] mod_q
);
  AST_FB_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> $past(rf_tick_i)); // R9
  AST_FB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R9
  AST_PRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_pulse_o |=> !pre_pulse_o); // R3
  AST_REF_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(ref_tick_i)); // R10
  AST_N_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_cur_o >= (p8_q ? N_W'(64) : N_W'(16))); // R7
  AST_CLAMP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clamp_o |-> n_cur_o <= (p8_q ? N_W'(65) : N_W'(17))); // R7
  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < mod_q); // R4
  AST_N_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fb_pulse_o && !$past(start_q)) |-> $stable(n_cur_o)); // R8
endmodule

bind fnd_fb_divider fnd_fb_divider_chk #(.N_W(N_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rf_tick_i(rf_tick_i), .ref_tick_i(ref_tick_i),
  .fb_pulse_o(fb_pulse_o), .pre_pulse_o(pre_pulse_o), .ref_pulse_o(ref_pulse_o),
  .n_cur_o(n_cur_o), .int_clamp_o(int_clamp_o), .start_q(start_q),
  .p8_q(p8_act), .acc_q(acc_cur), .mod_q(mod_cur)
);

// File: tb/fnd_fb_divider_bench.sv
`timescale 1ns/1ps
module fnd_fb_divider_bench;
  localparam int INT_W = 12, FRAC_W = 12, REF_W = 4, N_W = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0, rf_tick = 1'b0, ref_tick = 1'b0, psc_v = 1'b0;
  logic [INT_W-1:0]  int_v = '0;
  logic [FRAC_W-1:0] frac_v = '0, mod_v = '0;
  logic [REF_W-1:0]  rdiv_v = '0;
  logic              fb_pulse, pre_pulse, ref_pulse, int_clamp;
  logic [N_W-1:0]    n_cur;

  fnd_fb_divider u_fnd_fb_divider (
    .clk_i(clk), .rst_ni(rst_n), .rf_tick_i(rf_tick), .ref_tick_i(ref_tick),
    .int_i(int_v), .frac_i(frac_v), .mod_i(mod_v), .psc_sel_i(psc_v), .ref_div_i(rdiv_v),
    .fb_pulse_o(fb_pulse), .pre_pulse_o(pre_pulse), .ref_pulse_o(ref_pulse),
    .n_cur_o(n_cur), .int_clamp_o(int_clamp)
  );

  int total = 0, bad = 0;
  int b_acc = 0, exp_n = 0;
  bit exp_cl = 1'b0;
  int pre_len[32];
  int pre_num = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int iv, input int fv, input int mv, input bit p8,
                            output int n, output bit cl);
    int me, fe, s, mn;
    bit c;
    me = (mv == 0) ? 1 : mv;
    fe = (fv >= me) ? me - 1 : fv;
    if (b_acc >= me) b_acc = 0;
    s = b_acc + fe;
    c = s >= me;
    b_acc = c ? s - me : s;
    mn = p8 ? 64 : 16;
    cl = iv < mn;
    n = (cl ? mn : iv) + int'(c);
  endtask

  task automatic do_reset(input int iv, input int fv, input int mv, input bit p8);
    @(negedge clk);
    rst_n = 1'b0; rf_tick = 1'b0; ref_tick = 1'b0;
    int_v = INT_W'(iv); frac_v = FRAC_W'(fv); mod_v = FRAC_W'(mv); psc_v = p8;
    b_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_step(iv, fv, mv, p8, exp_n, exp_cl);
  endtask

  // runs one division; len = ticks spent, expn = model value for it
  task automatic run_div(input int gap, output int len, output int ncur,
                         output int expn, output bit clo);
    int since = 0, k = 0;
    bit fin = 1'b0;
    expn = exp_n; ncur = int'(n_cur); clo = int_clamp; len = 0; pre_num = 0;
    while (!fin) begin
      @(negedge clk);
      if (pre_pulse) begin
        if (pre_num < 32) pre_len[pre_num] = since;
        pre_num++;
        since = 0;
      end
      if (fb_pulse) begin
        fin = 1'b1;
        rf_tick = 1'b0;
        model_step(int'(int_v), int'(frac_v), int'(mod_v), psc_v, exp_n, exp_cl);
      end else begin
        rf_tick = (k % (gap + 1)) == 0;
        k++;
        if (rf_tick) begin since++; len++; end
        if (k > 5000) begin
          chk(1'b0, "R9 no division end", len, expn);
          fin = 1'b1;
          rf_tick = 1'b0;
        end
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; rf_tick = 1'b1; ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(!fb_pulse && !pre_pulse && !ref_pulse, "R1 pulses low in reset",
        int'({fb_pulse, pre_pulse, ref_pulse}), 0);
    chk(n_cur == N_W'(16), "R1 n_cur reset", int'(n_cur), 16);
    chk(!int_clamp, "R1 clamp reset", int'(int_clamp), 0);
    rf_tick = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic t_integer;
    int len, nc, en;
    bit cl;
    do_reset(37, 0, 5, 1'b0);
    for (int i = 0; i < 3; i++) begin
      run_div(0, len, nc, en, cl);
      chk(len == 37, "R2 integer p4", len, 37);
    end
    do_reset(100, 0, 9, 1'b1);
    for (int i = 0; i < 2; i++) begin
      run_div(0, len, nc, en, cl);
      chk(len == 100 && nc == 100, "R2 integer p8", len, 100);
    end
  endtask

  task automatic t_swallow(input int n, input bit p8);
    int len, nc, en, p, b, a, e;
    bit cl;
    p = p8 ? 8 : 4;
    b = n / p;
    a = n % p;
    do_reset(n, 0, 3, p8);
    run_div(0, len, nc, en, cl);
    chk(pre_num == b, "R3 prescaler cycles", pre_num, b);
    for (int i = 0; i < b && i < 32; i++) begin
      e = (i < a) ? p + 1 : p;
      chk(pre_len[i] == e, "R3 prescaler spacing", pre_len[i], e);
    end
  endtask

  task automatic t_dither;
    int len, nc, en;
    bit cl;
    int seq[6] = '{20, 20, 21, 20, 20, 21};
    do_reset(20, 1, 3, 1'b0);
    for (int i = 0; i < 6; i++) begin
      run_div(0, len, nc, en, cl);
      chk(len == seq[i], "R4 carry position", len, seq[i]);
      chk(nc == seq[i], "R4 n_cur dither", nc, seq[i]);
    end
  endtask

  task automatic t_average(input int iv, input int fv, input int mv);
    int len, nc, en, sum;
    bit cl;
    sum = 0;
    do_reset(iv, fv, mv, 1'b0);
    for (int i = 0; i < mv; i++) begin
      run_div(0, len, nc, en, cl);
      sum += len;
      if (len != en) chk(1'b0, "R5 division vs model", len, en);
    end
    chk(sum == mv * iv + fv, "R5 mean ratio", sum, mv * iv + fv);
  endtask

  task automatic t_frac_clamp;
    int len, nc, en;
    bit cl;
    int seq[4] = '{25, 26, 26, 26};
    do_reset(25, 9, 4, 1'b0);
    for (int i = 0; i < 4; i++) begin
      run_div(0, len, nc, en, cl);
      chk(len == seq[i], "R6 frac above mod", len, seq[i]);
    end
    do_reset(25, 3, 0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      run_div(0, len, nc, en, cl);
      chk(len == 25, "R6 zero modulus", len, 25);
    end
  endtask

  task automatic t_min_int(input int iv, input int fv, input int mv, input bit p8,
                           input int e0, input int e1, input bit ecl);
    int len, nc, en;
    bit cl;
    do_reset(iv, fv, mv, p8);
    run_div(0, len, nc, en, cl);
    chk(len == e0, "R7 floor divide", len, e0);
    chk(cl == ecl, "R7 clamp flag", int'(cl), int'(ecl));
    run_div(0, len, nc, en, cl);
    chk(len == e1, "R7 floor plus carry", len, e1);
  endtask

  task automatic t_update;
    int len, nc, en;
    bit cl;
    do_reset(40, 0, 5, 1'b0);
    run_div(0, len, nc, en, cl);
    chk(len == 40, "R8 first division", len, 40);
    fork
      run_div(0, len, nc, en, cl);
      begin
        repeat (10) @(negedge clk);
        int_v = INT_W'(50);
      end
    join
    chk(len == 40 && nc == 40, "R8 change held mid-division", len, 40);
    run_div(0, len, nc, en, cl);
    chk(len == 50 && nc == 50, "R8 change at boundary", len, 50);
    fork
      run_div(0, len, nc, en, cl);
      begin
        repeat (5) @(negedge clk);
        psc_v = 1'b1;
      end
    join
    run_div(0, len, nc, en, cl);
    chk(len == 64 && cl, "R8 prescaler change at boundary", len, 64);
  endtask

  task automatic t_gaps;
    int len, nc, en;
    bit cl;
    do_reset(27, 0, 3, 1'b0);
    run_div(2, len, nc, en, cl);
    chk(len == 27, "R9 gapped ticks", len, 27);
    @(negedge clk);
    chk(!fb_pulse, "R9 pulse one cycle", int'(fb_pulse), 0);
  endtask

  task automatic t_ref(input int dv, input int nt);
    int cnt, first, e;
    cnt = 0; first = -1;
    do_reset(20, 0, 3, 1'b0);
    rdiv_v = REF_W'(dv);
    for (int i = 0; i <= nt; i++) begin
      @(negedge clk);
      if (ref_pulse) begin
        cnt++;
        if (first < 0) first = i;
      end
      ref_tick = (i < nt);
    end
    ref_tick = 1'b0;
    e = (dv == 0) ? 1 : dv;
    chk(cnt == nt / e, "R10 reference pulse count", cnt, nt / e);
    chk(first == e, "R10 first reference pulse", first, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_integer();
    t_swallow(22, 1'b0);
    t_swallow(75, 1'b1);
    t_dither();
    t_average(30, 5, 7);
    t_average(40, 12, 13);
    t_frac_clamp();
    t_min_int(10, 0, 5, 1'b0, 16, 16, 1'b1);
    t_min_int(16, 0, 5, 1'b0, 16, 16, 1'b0);
    t_min_int(63, 0, 5, 1'b1, 64, 64, 1'b1);
    t_min_int(64, 0, 5, 1'b1, 64, 64, 1'b0);
    t_min_int(10, 1, 2, 1'b0, 16, 17, 1'b1);
    t_update();
    t_gaps();
    t_ref(5, 30);
    t_ref(0, 12);
    t_ref(15, 30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule